// File: doc/BRIEF.md
# Dual-Strobe Byte/Word FIFO Data Port

This block is the data register a CPU reads and writes to reach a byte-wide FIFO. It sits on a 16-bit data bus. It has two write strobes, one for the high byte lane and one for the low byte lane, and it has a read strobe. A mode input selects whether the bus acts as 16 bits or as 8 bits wide. Each write access pushes one or two bytes into an internal circular buffer of parameterised depth. Each read access pops one or two bytes and places them on a registered read-data bus.

In word mode the strobes chosen for each access decide its size. Low plus high is a word, and low alone is a byte. In byte mode only the low lane carries data. Read data is copied onto both halves of the bus, so software can read the byte from either lane. The block samples every strobe on the system clock and acts only on the cycle in which the strobe rises. A strobe held for several cycles therefore moves data only once. A write that would overrun the buffer, or a read with too little data, is refused as a whole. It raises a one-cycle error flag.

Top module: `fifo_data_port`

## Requirements
- R1: After reset the read-data bus is zero, both error flags are low and the buffer is empty.
- R2: With `byte_mode`=0, a write with `wr_hi` and `wr_lo` both asserted pushes `bus_wdata[7:0]` first and `bus_wdata[15:8]` second. A word read places the first byte popped on `bus_rdata[7:0]` and the second on `bus_rdata[15:8]`.
- R3: A write that needs more bytes than the free space (two for a word, one for a byte) stores nothing and pulses `overflow`. The fill level never exceeds DEPTH.
- R4: With `byte_mode`=0, a write with only `wr_lo` asserted pushes one byte taken from `bus_wdata[7:0]`.
- R5: With `byte_mode`=1, every write pushes exactly one byte from `bus_wdata[7:0]`, even when `wr_hi` is also asserted. Bits 15:8 are discarded.
- R6: `wr_hi` asserted without `wr_lo` starts no write in either mode, and the buffer contents are unchanged.
- R7: With `byte_mode`=1, a read pops one byte and drives it on both `bus_rdata[15:8]` and `bus_rdata[7:0]`.
- R8: A read that needs more bytes than are stored (one in byte mode, two in word mode) pops nothing, drives zero on `bus_rdata` and pulses `underrun`.
- R9: Each access acts only on the first clock at which its strobe is sampled high. Holding a strobe for more cycles moves no further data.
- R10: `overflow` and `underrun` are high for exactly the one cycle after the clock edge that refused the access. `bus_rdata` holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all strobes are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_mode | input | 1 | 0: 16-bit bus, 1: 8-bit bus |
| wr_hi | input | 1 | High byte lane write strobe, active high |
| wr_lo | input | 1 | Low byte lane write strobe, active high; starts every write |
| rd_stb | input | 1 | Read strobe, active high |
| bus_wdata | input | 2*BYTE_W | Write data from the CPU |
| bus_rdata | output | 2*BYTE_W | Registered read data, held between reads |
| overflow | output | 1 | One-cycle pulse: a write was refused for lack of space |
| underrun | output | 1 | One-cycle pulse: a read was refused for lack of data |

## Verification
The bound checker watches several rules on every cycle. The fill level must stay within DEPTH, and a refused write must never raise it. A refused read must return zero and pop nothing. Byte-mode reads must mirror the byte on both lanes, each strobe may act only once per assertion, and a lone high strobe must leave the buffer untouched. Byte order across the lanes, exact overflow and underrun boundaries at odd and even fill levels, and the discarding of the high lane in byte mode depend on data values. Only the bench's directed sweeps show these, by filling and draining the buffer and comparing each value against its own model.

// File: rtl/fdp_pkg.sv
package fdp_pkg;
   // Number of bytes moved by one access.
   typedef enum logic [1:0] {
      XFER_NONE = 2'd0,
      XFER_BYTE = 2'd1,
      XFER_WORD = 2'd2
   } xfer_e;

   function automatic int unsigned xfer_bytes(input xfer_e k);
      return (k == XFER_WORD) ? 2 : ((k == XFER_BYTE) ? 1 : 0);
   endfunction
endpackage

// File: rtl/fdp_strobe_edge.sv
module fdp_strobe_edge #(
   parameter int N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] level,
   output logic [N-1:0] rise
);
   generate
      if (N < 1) begin : g_bad_n
         $error("fdp_strobe_edge: N must be at least 1");
      end
   endgenerate

   logic [N-1:0] level_q;

   for (genvar i = 0; i < N; i++) begin : g_edge
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) level_q[i] <= 1'b0;
         else        level_q[i] <= level[i];
      end
      assign rise[i] = level[i] & ~level_q[i];
   end
endmodule

// File: rtl/fdp_byte_fifo.sv
module fdp_byte_fifo
   import fdp_pkg::*;
#(
   parameter int BYTE_W = 8,
   parameter int DEPTH  = 16,
   localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  xfer_e             push_kind,
   input  logic [BYTE_W-1:0] push_d0,
   input  logic [BYTE_W-1:0] push_d1,
   input  xfer_e             pop_kind,
   output logic [BYTE_W-1:0] head0,
   output logic [BYTE_W-1:0] head1,
   output logic [CNT_W-1:0]  fill
);
   localparam bit POW2 = ((DEPTH & (DEPTH - 1)) == 0);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("fdp_byte_fifo: DEPTH must be at least 2");
      end
      if (BYTE_W < 1) begin : g_bad_width
         $error("fdp_byte_fifo: BYTE_W must be positive");
      end
   endgenerate

   logic [BYTE_W-1:0] mem [DEPTH];
   logic [AW-1:0]     wp, wp1, wp2;
   logic [AW-1:0]     rp, rp1, rp2;

   // Pointer stepping: free wrap for power-of-two depths, compare otherwise.
   generate
      if (POW2) begin : g_pow2
         assign wp1 = wp + AW'(1);
         assign wp2 = wp + AW'(2);
         assign rp1 = rp + AW'(1);
         assign rp2 = rp + AW'(2);
      end else begin : g_wrap
         assign wp1 = (wp  == AW'(DEPTH - 1)) ? '0 : wp  + AW'(1);
         assign wp2 = (wp1 == AW'(DEPTH - 1)) ? '0 : wp1 + AW'(1);
         assign rp1 = (rp  == AW'(DEPTH - 1)) ? '0 : rp  + AW'(1);
         assign rp2 = (rp1 == AW'(DEPTH - 1)) ? '0 : rp1 + AW'(1);
      end
   endgenerate

   assign head0 = mem[rp];
   assign head1 = mem[rp1];

   always_ff @(posedge clk) begin
      if (push_kind != XFER_NONE) mem[wp]  <= push_d0;
      if (push_kind == XFER_WORD) mem[wp1] <= push_d1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp   <= '0;
         rp   <= '0;
         fill <= '0;
      end else begin
         case (push_kind)
            XFER_BYTE: wp <= wp1;
            XFER_WORD: wp <= wp2;
            default:   wp <= wp;
         endcase
         case (pop_kind)
            XFER_BYTE: rp <= rp1;
            XFER_WORD: rp <= rp2;
            default:   rp <= rp;
         endcase
         fill <= fill + CNT_W'(xfer_bytes(push_kind)) - CNT_W'(xfer_bytes(pop_kind));
      end
   end
endmodule

// File: rtl/fdp_access_decode.sv
module fdp_access_decode
   import fdp_pkg::*;
#(
   parameter int DEPTH  = 16,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             byte_mode,
   input  logic             wr_hi,
   input  logic             wr_go,
   input  logic             rd_go,
   input  logic [CNT_W-1:0] fill,
   output xfer_e            push_kind,
   output xfer_e            pop_kind,
   output logic             ovf_now,
   output logic             unr_now
);
   logic       word_wr;
   logic       wr_fits;
   logic       rd_fits;
   logic [CNT_W-1:0] space;

   // Room is judged on the level before any pop in the same cycle.
   assign space   = CNT_W'(DEPTH) - fill;
   assign word_wr = wr_hi & ~byte_mode;
   assign wr_fits = word_wr ? (space >= CNT_W'(2)) : (space >= CNT_W'(1));
   assign rd_fits = byte_mode ? (fill >= CNT_W'(1)) : (fill >= CNT_W'(2));

   always_comb begin
      push_kind = XFER_NONE;
      pop_kind  = XFER_NONE;
      ovf_now   = 1'b0;
      unr_now   = 1'b0;
      if (wr_go) begin
         if (wr_fits) push_kind = word_wr ? XFER_WORD : XFER_BYTE;
         else         ovf_now   = 1'b1;
      end
      if (rd_go) begin
         if (rd_fits) pop_kind = byte_mode ? XFER_BYTE : XFER_WORD;
         else         unr_now  = 1'b1;
      end
   end
endmodule

// File: rtl/fifo_data_port.sv
module fifo_data_port
   import fdp_pkg::*;
#(
   parameter int BYTE_W = 8,
   parameter int DEPTH  = 16,
   localparam int BUS_W = 2 * BYTE_W,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             byte_mode,
   input  logic             wr_hi,
   input  logic             wr_lo,
   input  logic             rd_stb,
   input  logic [BUS_W-1:0] bus_wdata,
   output logic [BUS_W-1:0] bus_rdata,
   output logic             overflow,
   output logic             underrun
);
   logic [1:0]        rise;
   logic              wr_go;
   logic              rd_go;
   xfer_e             push_kind;
   xfer_e             pop_kind;
   logic              ovf_now;
   logic              unr_now;
   logic [BYTE_W-1:0] head0;
   logic [BYTE_W-1:0] head1;
   logic [CNT_W-1:0]  fill;

   // Every write is started by the low lane strobe; the high lane only widens it.
   fdp_strobe_edge #(.N(2)) u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .level ({rd_stb, wr_lo}),
      .rise  (rise)
   );
   assign wr_go = rise[0];
   assign rd_go = rise[1];

   fdp_access_decode #(.DEPTH(DEPTH)) u_dec (
      .byte_mode (byte_mode),
      .wr_hi     (wr_hi),
      .wr_go     (wr_go),
      .rd_go     (rd_go),
      .fill      (fill),
      .push_kind (push_kind),
      .pop_kind  (pop_kind),
      .ovf_now   (ovf_now),
      .unr_now   (unr_now)
   );

   fdp_byte_fifo #(.BYTE_W(BYTE_W), .DEPTH(DEPTH)) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push_kind (push_kind),
      .push_d0   (bus_wdata[BYTE_W-1:0]),
      .push_d1   (bus_wdata[BUS_W-1:BYTE_W]),
      .pop_kind  (pop_kind),
      .head0     (head0),
      .head1     (head1),
      .fill      (fill)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rdata <= '0;
         overflow  <= 1'b0;
         underrun  <= 1'b0;
      end else begin
         overflow <= ovf_now;
         underrun <= unr_now;
         case (pop_kind)
            XFER_WORD: bus_rdata <= {head1, head0};
            XFER_BYTE: bus_rdata <= {head0, head0};
            default:   if (unr_now) bus_rdata <= '0;
         endcase
      end
   end
endmodule

// File: rtl/fdp_checker.sv
module fdp_checker #(
   parameter int BYTE_W = 8,
   parameter int DEPTH  = 16,
   localparam int BUS_W = 2 * BYTE_W,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             byte_mode,
   input logic             wr_hi,
   input logic             wr_lo,
   input logic             rd_stb,
   input logic [BUS_W-1:0] bus_rdata,
   input logic             overflow,
   input logic             underrun,
   input logic             wr_go,
   input logic             rd_go,
   input logic [CNT_W-1:0] fill
);
   p_fill_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      fill <= CNT_W'(DEPTH));

   p_no_overflow_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
      overflow |-> fill <= $past(fill));

   p_lone_hi_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hi && !wr_lo && !rd_stb) |=> fill == $past(fill));

   p_mirror_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_go && byte_mode) |=> bus_rdata[BUS_W-1:BYTE_W] == bus_rdata[BYTE_W-1:0]);

   p_underrun_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      underrun |-> bus_rdata == '0);

   p_underrun_no_pop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      underrun |-> fill >= $past(fill));

   p_write_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_go |=> !wr_go);

   p_read_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rd_go |=> !rd_go);

   p_ovf_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      overflow |=> !overflow);

   p_unr_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      underrun |=> !underrun);

   p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_go |=> $stable(bus_rdata));
endmodule

bind fifo_data_port fdp_checker #(.BYTE_W(BYTE_W), .DEPTH(DEPTH)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .byte_mode (byte_mode),
   .wr_hi     (wr_hi),
   .wr_lo     (wr_lo),
   .rd_stb    (rd_stb),
   .bus_rdata (bus_rdata),
   .overflow  (overflow),
   .underrun  (underrun),
   .wr_go     (wr_go),
   .rd_go     (rd_go),
   .fill      (fill)
);

// File: tb/tb_fifo_data_port.sv
`timescale 1ns/1ps
module tb_fifo_data_port;
   localparam int DEPTH = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        byte_mode = 1'b0;
   logic        wr_hi = 1'b0;
   logic        wr_lo = 1'b0;
   logic        rd_stb = 1'b0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        overflow;
   logic        underrun;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;
   logic [7:0] model [$];

   always #5 clk = ~clk;

   fifo_data_port #(.BYTE_W(8), .DEPTH(DEPTH)) dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .byte_mode (byte_mode),
      .wr_hi     (wr_hi),
      .wr_lo     (wr_lo),
      .rd_stb    (rd_stb),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .overflow  (overflow),
      .underrun  (underrun)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // One write access: strobes up for one cycle, flag checked after the edge.
   task automatic write_acc(input logic m8, input logic hi, input logic lo,
                            input logic [15:0] d, input string tag);
      int  need;
      bit  exp_ovf;
      need    = (hi && lo && !m8) ? 2 : 1;
      exp_ovf = lo && (model.size() + need > DEPTH);
      if (lo && !exp_ovf) begin
         model.push_back(d[7:0]);
         if (need == 2) model.push_back(d[15:8]);
      end
      @(negedge clk);
      byte_mode = m8; wr_hi = hi; wr_lo = lo; bus_wdata = d;
      @(negedge clk);
      check({tag, " overflow"}, {31'd0, overflow}, {31'd0, exp_ovf});
      wr_hi = 1'b0; wr_lo = 1'b0;
      @(negedge clk);
      check("R10 overflow pulse", {31'd0, overflow}, 32'd0);
   endtask

   // One read access; expected data follows from the byte model.
   task automatic read_acc(input logic m8, input string tag);
      int          need;
      logic [15:0] exp_d;
      bit          exp_unr;
      need = m8 ? 1 : 2;
      if (model.size() >= need) begin
         exp_d   = m8 ? {model[0], model[0]} : {model[1], model[0]};
         exp_unr = 1'b0;
         void'(model.pop_front());
         if (need == 2) void'(model.pop_front());
      end else begin
         exp_d   = '0;
         exp_unr = 1'b1;
      end
      @(negedge clk);
      byte_mode = m8; rd_stb = 1'b1;
      @(negedge clk);
      check({tag, " rdata"}, {16'd0, bus_rdata}, {16'd0, exp_d});
      check({tag, " underrun"}, {31'd0, underrun}, {31'd0, exp_unr});
      rd_stb = 1'b0;
      @(negedge clk);
      check("R10 underrun pulse", {31'd0, underrun}, 32'd0);
      check("R10 rdata hold", {16'd0, bus_rdata}, {16'd0, exp_d});
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL R9 watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 rdata after reset", {16'd0, bus_rdata}, 32'd0);
      check("R1 overflow after reset", {31'd0, overflow}, 32'd0);
      check("R1 underrun after reset", {31'd0, underrun}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      read_acc(1'b1, "R1 R8 empty byte read");
      read_acc(1'b0, "R8 empty word read");

      // Word sweep: fill with words, one past capacity, drain.
      for (int i = 0; i <= DEPTH / 2; i++)
         write_acc(1'b0, 1'b1, 1'b1, 16'((i * 16'h1111) ^ 16'h0F20), "R2 R3 word write");
      for (int i = 0; i <= DEPTH / 2; i++)
         read_acc(1'b0, "R2 word read");

      // Odd fill: a byte first, then words until only one byte of room remains.
      write_acc(1'b0, 1'b0, 1'b1, 16'hEE5A, "R4 lone low byte");
      for (int i = 0; i < DEPTH / 2; i++)
         write_acc(1'b0, 1'b1, 1'b1, 16'(16'hC381 + i * 16'h0203), "R3 word into odd fill");
      write_acc(1'b0, 1'b0, 1'b1, 16'h77A4, "R3 byte into last slot");
      write_acc(1'b0, 1'b0, 1'b1, 16'h1234, "R3 byte into full");
      write_acc(1'b0, 1'b1, 1'b1, 16'h5678, "R3 word into full");
      for (int i = 0; i < DEPTH / 2; i++)
         read_acc(1'b0, "R2 R4 drain odd");
      read_acc(1'b0, "R8 word read on empty");

      // Byte mode: both strobes give a byte, lone high strobe is ignored.
      for (int i = 0; i < DEPTH; i++)
         write_acc(1'b1, 1'(i & 1), 1'b1, 16'((i * 16'h3B17) + 16'h9D02), "R5 byte mode write");
      write_acc(1'b1, 1'b1, 1'b1, 16'hABCD, "R3 R5 byte mode full");
      write_acc(1'b1, 1'b1, 1'b0, 16'h4242, "R6 lone high byte mode");
      for (int i = 0; i < DEPTH; i++)
         read_acc(1'b1, "R5 R7 byte mode read");
      write_acc(1'b1, 1'b1, 1'b0, 16'h6161, "R6 lone high on empty");
      write_acc(1'b0, 1'b1, 1'b0, 16'h6262, "R6 lone high word mode");
      read_acc(1'b1, "R6 R8 nothing stored");

      // Word read with a single byte stored is refused; byte read then gets it.
      write_acc(1'b1, 1'b0, 1'b1, 16'h00C7, "R5 single byte");
      read_acc(1'b0, "R8 word read short");
      read_acc(1'b1, "R7 R8 byte after short");

      // Held strobes act once.
      @(negedge clk);
      byte_mode = 1'b0; wr_hi = 1'b1; wr_lo = 1'b1; bus_wdata = 16'hB00F;
      model.push_back(8'h0F); model.push_back(8'hB0);
      repeat (4) @(negedge clk);
      wr_hi = 1'b0; wr_lo = 1'b0;
      write_acc(1'b0, 1'b1, 1'b1, 16'h2D3C, "R9 word after held write");
      @(negedge clk);
      rd_stb = 1'b1;
      repeat (4) @(negedge clk);
      check("R9 held read data", {16'd0, bus_rdata}, 32'h0000B00F);
      rd_stb = 1'b0;
      void'(model.pop_front()); void'(model.pop_front());
      read_acc(1'b0, "R9 second word after held read");
      read_acc(1'b0, "R9 R8 nothing left");

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule